// File: doc/BRIEF.md
# ROM Patch Address Comparator Unit

This block sits on the read return path of a read-only memory. Each bus read address is compared in parallel against a bank of programmable watch addresses. When an enabled comparator matches, the word returned to the requester is replaced in the same cycle as the memory data arrives. Depending on the comparator, the replacement is either a stored 32-bit data word (data fix) or a patch instruction (opcode patch). An opcode patch comes in two forms: a full 32-bit word for 32-bit code, or a 16-bit halfword dropped into the addressed lane for compact 16-bit code.

Software sets up the unit through a small word-indexed register port. Through that port it loads the watch addresses, the data-fix words, the patch words, the per-comparator enables, the fix/patch mode bits and a global disable. A status register holds the index of the comparator behind the most recent substitution, plus a sticky flag that marks a collision, meaning an access that hit several comparators at once. Each substitution also drives a single-cycle event output.

Top module: `rom_patch_ctrl`

## Requirements
- R1: After reset every configuration and status register reads 0, no comparator is enabled, and read data passes through unchanged with `patch_evt_o` low.
- R2: A comparator whose bit in the enable register (index 1, bits NUM_CMP-1:0) is 0 never matches.
- R3: A comparator register (index 16+n) holds the watch address in bits 22:1 and the 16-bit-code select in bit 0. A match compares only bus address bits 22:1, so bus address bit 0 and bits 31:23 have no effect.
- R4: Comparator n, for n below NUM_FIX (8), returns data-fix register n (index 8+n) on a match when its mode bit (control register index 0, bit n) is 1.
- R5: An opcode-patch match with select bit 0 returns the 32-bit patch word (index 3).
- R6: An opcode-patch match with select bit 1 returns the patch halfword (index 4, bits 15:0) in the upper lane when bus address bit 1 is 1, and in the lower lane otherwise. The other lane carries the memory data.
- R7: Comparators NUM_FIX and above only produce opcode patches. The select bit has no effect on a data-fix match.
- R8: While control bit 29 is 1, no substitution or event occurs and the status register is left unchanged.
- R9: When several enabled comparators match, the lowest-numbered one supplies the result.
- R10: On every substitution, status bits 5:0 (index 2) load the winning comparator's index on the next clock edge.
- R11: Status bit 17 is set when a substitution involves more than one matching comparator. It stays set until software writes 1 to bit 17; if a new collision occurs in the same cycle, setting wins.
- R12: `patch_evt_o` is high, combinationally, exactly during a read cycle (`rd_valid_i` high) that is substituted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 6 | Register word index |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational on cfg_addr_i) |
| rd_valid_i | input | 1 | Memory read data return valid |
| rd_addr_i | input | 32 | Address of the returning read |
| mem_rdata_i | input | 32 | Raw memory read data |
| rd_data_o | output | 32 | Read data after substitution |
| patch_evt_o | output | 1 | Substitution event pulse |

## Verification
The bench builds the unit with the default parameters, NUM_CMP = 16 and NUM_FIX = 8. These defaults place the boundary between fix-capable comparators (0 to 7) and opcode-only comparators (8 to 15) inside the test, and they let comparator 15 exercise the widest source index. With them the bench can run collisions between a low opcode comparator and a higher data-fix comparator, show that the select bit is ignored on a data-fix match, and cover both halfword lanes with neighbouring opcode-only comparators.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int CFG_AW      = 6;
  localparam int DW          = 32;
  localparam int WATCH_LO    = 1;
  localparam int WATCH_HI    = 22;
  localparam int WATCH_W     = WATCH_HI - WATCH_LO + 1;
  localparam int SRC_W       = 6;
  localparam int DIS_BIT     = 29;
  localparam int COLL_BIT    = 17;

  localparam logic [CFG_AW-1:0] IDX_CTRL   = 6'd0;
  localparam logic [CFG_AW-1:0] IDX_ENA    = 6'd1;
  localparam logic [CFG_AW-1:0] IDX_STAT   = 6'd2;
  localparam logic [CFG_AW-1:0] IDX_WORD   = 6'd3;
  localparam logic [CFG_AW-1:0] IDX_HALF   = 6'd4;
  localparam int               FIX_BASE   = 8;
  localparam int               CMP_BASE   = 16;

  typedef enum logic [1:0] {
    SUB_NONE  = 2'd0,
    SUB_FIX   = 2'd1,
    SUB_WORD  = 2'd2,
    SUB_HALF  = 2'd3
  } sub_kind_e;
endpackage

// File: rtl/rpc_cfg.sv
module rpc_cfg
  import rpc_pkg::*;
#(
  parameter int NUM_CMP = 16,
  parameter int NUM_FIX = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_wr_i,
  input  logic [CFG_AW-1:0]     cfg_addr_i,
  input  logic [DW-1:0]         cfg_wdata_i,
  output logic [DW-1:0]         cfg_rdata_o,
  input  logic [DW-1:0]         stat_word_i,
  output logic [WATCH_W-1:0]    cmp_addr_o [NUM_CMP],
  output logic [NUM_CMP-1:0]    cmp_half_o,
  output logic [NUM_CMP-1:0]    cmp_en_o,
  output logic [NUM_FIX-1:0]    fix_mode_o,
  output logic [DW-1:0]         fix_data_o [NUM_FIX],
  output logic [DW-1:0]         patch_word_o,
  output logic [15:0]           patch_half_o,
  output logic                  dis_o
);
  logic [NUM_FIX-1:0] mode_q;
  logic               dis_q;
  logic [NUM_CMP-1:0] en_q;
  logic [DW-1:0]      word_q;
  logic [15:0]        half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dis_q  <= 1'b0;
      en_q   <= '0;
      word_q <= '0;
      half_q <= '0;
    end else if (cfg_wr_i) begin
      unique case (cfg_addr_i)
        IDX_CTRL: begin
          mode_q <= cfg_wdata_i[NUM_FIX-1:0];
          dis_q  <= cfg_wdata_i[DIS_BIT];
        end
        IDX_ENA:  en_q   <= cfg_wdata_i[NUM_CMP-1:0];
        IDX_WORD: word_q <= cfg_wdata_i;
        IDX_HALF: half_q <= cfg_wdata_i[15:0];
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_FIX; k++) begin : g_fix
    logic [DW-1:0] fix_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        fix_q <= '0;
      else if (cfg_wr_i && cfg_addr_i == CFG_AW'(FIX_BASE + k))
        fix_q <= cfg_wdata_i;
    end
    assign fix_data_o[k] = fix_q;
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic [WATCH_W-1:0] addr_q;
    logic               half_sel_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q     <= '0;
        half_sel_q <= 1'b0;
      end else if (cfg_wr_i && cfg_addr_i == CFG_AW'(CMP_BASE + k)) begin
        addr_q     <= cfg_wdata_i[WATCH_HI:WATCH_LO];
        half_sel_q <= cfg_wdata_i[0];
      end
    end
    assign cmp_addr_o[k] = addr_q;
    assign cmp_half_o[k] = half_sel_q;
  end

  always_comb begin
    cfg_rdata_o = '0;
    unique case (cfg_addr_i)
      IDX_CTRL: begin
        cfg_rdata_o[NUM_FIX-1:0] = mode_q;
        cfg_rdata_o[DIS_BIT]     = dis_q;
      end
      IDX_ENA:  cfg_rdata_o[NUM_CMP-1:0] = en_q;
      IDX_STAT: cfg_rdata_o = stat_word_i;
      IDX_WORD: cfg_rdata_o = word_q;
      IDX_HALF: cfg_rdata_o[15:0] = half_q;
      default: begin
        for (int k = 0; k < NUM_FIX; k++)
          if (cfg_addr_i == CFG_AW'(FIX_BASE + k)) cfg_rdata_o = fix_data_o[k];
        for (int k = 0; k < NUM_CMP; k++)
          if (cfg_addr_i == CFG_AW'(CMP_BASE + k)) begin
            cfg_rdata_o[WATCH_HI:WATCH_LO] = cmp_addr_o[k];
            cfg_rdata_o[0]                 = cmp_half_o[k];
          end
      end
    endcase
  end

  assign cmp_en_o     = en_q;
  assign fix_mode_o   = mode_q;
  assign patch_word_o = word_q;
  assign patch_half_o = half_q;
  assign dis_o        = dis_q;

  p_ena_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && cfg_addr_i == IDX_ENA |=> cmp_en_o == $past(cfg_wdata_i[NUM_CMP-1:0]));
endmodule

// File: rtl/rpc_match.sv
module rpc_match
  import rpc_pkg::*;
#(
  parameter int NUM_CMP = 16,
  localparam int IDX_W  = $clog2(NUM_CMP)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DW-1:0]         rd_addr_i,
  input  logic [WATCH_W-1:0]    cmp_addr_i [NUM_CMP],
  input  logic [NUM_CMP-1:0]    cmp_en_i,
  output logic                  hit_o,
  output logic                  multi_o,
  output logic [IDX_W-1:0]      win_idx_o
);
  logic [NUM_CMP-1:0] hit_vec;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign hit_vec[k] = cmp_en_i[k] && (rd_addr_i[WATCH_HI:WATCH_LO] == cmp_addr_i[k]);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    win_idx_o = '0;
    for (int k = NUM_CMP - 1; k >= 0; k--)
      if (hit_vec[k]) win_idx_o = IDX_W'(k);
  end

  assign hit_o   = |hit_vec;
  assign multi_o = $countones(hit_vec) > 1;

  p_win_is_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> hit_vec[win_idx_o]);
  p_win_lowest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_vec & ((NUM_CMP'(1) << win_idx_o) - NUM_CMP'(1))) == '0);
  p_win_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> cmp_en_i[win_idx_o]);
endmodule

// File: rtl/rpc_status.sv
module rpc_status
  import rpc_pkg::*;
#(
  parameter int NUM_CMP = 16,
  localparam int IDX_W  = $clog2(NUM_CMP)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_i,
  input  logic               multi_i,
  input  logic [IDX_W-1:0]   win_idx_i,
  input  logic               clr_i,
  output logic [DW-1:0]      stat_word_o
);
  logic [SRC_W-1:0] src_q;
  logic             coll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      coll_q <= 1'b0;
    end else begin
      if (evt_i) src_q <= SRC_W'(win_idx_i);
      if (evt_i && multi_i) coll_q <= 1'b1;
      else if (clr_i)       coll_q <= 1'b0;
    end
  end

  always_comb begin
    stat_word_o              = '0;
    stat_word_o[SRC_W-1:0]   = src_q;
    stat_word_o[COLL_BIT]    = coll_q;
  end

  p_src_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> src_q == SRC_W'($past(win_idx_i)));
  p_src_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(src_q));
  p_coll_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i && multi_i |=> coll_q);
  p_coll_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_q && !clr_i |=> coll_q);
endmodule

// File: rtl/rom_patch_ctrl.sv
module rom_patch_ctrl
  import rpc_pkg::*;
#(
  parameter int NUM_CMP = 16,
  parameter int NUM_FIX = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [5:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              rd_valid_i,
  input  logic [31:0]       rd_addr_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [31:0]       rd_data_o,
  output logic              patch_evt_o
);
  localparam int IDX_W = $clog2(NUM_CMP);

  logic [WATCH_W-1:0] cmp_addr [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_half;
  logic [NUM_CMP-1:0] cmp_en;
  logic [NUM_FIX-1:0] fix_mode;
  logic [DW-1:0]      fix_data [NUM_FIX];
  logic [DW-1:0]      patch_word;
  logic [15:0]        patch_half;
  logic               dis;
  logic [DW-1:0]      stat_word;
  logic               hit, multi;
  logic [IDX_W-1:0]   win_idx;
  logic               evt;
  logic               stat_clr;
  sub_kind_e          kind;
  logic [DW-1:0]      fix_word;

  rpc_cfg #(.NUM_CMP(NUM_CMP), .NUM_FIX(NUM_FIX)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .stat_word_i  (stat_word),
    .cmp_addr_o   (cmp_addr),
    .cmp_half_o   (cmp_half),
    .cmp_en_o     (cmp_en),
    .fix_mode_o   (fix_mode),
    .fix_data_o   (fix_data),
    .patch_word_o (patch_word),
    .patch_half_o (patch_half),
    .dis_o        (dis)
  );

  rpc_match #(.NUM_CMP(NUM_CMP)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (rd_addr_i),
    .cmp_addr_i (cmp_addr),
    .cmp_en_i   (cmp_en),
    .hit_o      (hit),
    .multi_o    (multi),
    .win_idx_o  (win_idx)
  );

  assign evt      = rd_valid_i && hit && !dis;
  assign stat_clr = cfg_wr_i && cfg_addr_i == IDX_STAT && cfg_wdata_i[COLL_BIT];

  rpc_status #(.NUM_CMP(NUM_CMP)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .multi_i     (multi),
    .win_idx_i   (win_idx),
    .clr_i       (stat_clr),
    .stat_word_o (stat_word)
  );

  // substitution kind; only the first NUM_FIX comparators can fix data
  always_comb begin
    kind     = SUB_NONE;
    fix_word = '0;
    if (evt) begin
      kind = SUB_WORD;
      for (int k = 0; k < NUM_CMP; k++)
        if (win_idx == IDX_W'(k) && cmp_half[k]) kind = SUB_HALF;
      for (int k = 0; k < NUM_FIX; k++)
        if (win_idx == IDX_W'(k) && fix_mode[k]) begin
          kind     = SUB_FIX;
          fix_word = fix_data[k];
        end
    end
  end

  always_comb begin
    unique case (kind)
      SUB_FIX:  rd_data_o = fix_word;
      SUB_WORD: rd_data_o = patch_word;
      SUB_HALF: rd_data_o = rd_addr_i[1] ? {patch_half, mem_rdata_i[15:0]}
                                         : {mem_rdata_i[31:16], patch_half};
      default:  rd_data_o = mem_rdata_i;
    endcase
  end

  assign patch_evt_o = evt;

  p_pass_through_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis |-> (rd_data_o == mem_rdata_i && !patch_evt_o));
  p_evt_needs_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    patch_evt_o |-> rd_valid_i);
  p_idle_pass_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !patch_evt_o |-> rd_data_o == mem_rdata_i);
endmodule

// File: tb/test_rom_patch_ctrl.sv
module test_rom_patch_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        rd_valid_i = 1'b0;
  logic [31:0] rd_addr_i = '0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] rd_data_o;
  logic        patch_evt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] data;
    logic        evt;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  rom_patch_ctrl i_rom_patch_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i), .mem_rdata_i(mem_rdata_i),
    .rd_data_o(rd_data_o), .patch_evt_o(patch_evt_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(posedge clk); #1;
    cfg_wr_i = 1'b0;
  endtask

  task automatic rd_reg(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    cfg_addr_i = a;
    #1 chk(tag, cfg_rdata_o, exp);
  endtask

  // driver: one read return per call, expectation pushed to the scoreboard
  task automatic bus_rd(input string tag, input logic [31:0] a, input logic [31:0] m,
                        input logic [31:0] exp, input logic evt);
    exp_t e;
    e.data = exp; e.evt = evt; e.tag = tag;
    @(posedge clk); #1;
    q.push_back(e);
    rd_valid_i = 1'b1; rd_addr_i = a; mem_rdata_i = m;
    @(posedge clk); #1;
    rd_valid_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid_i) begin
        if (q.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard underflow actual=read expected=none");
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " data"}, rd_data_o, e.data);
          chk({e.tag, " evt"}, {31'b0, patch_evt_o}, {31'b0, e.evt});
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [31:0] WORD = 32'hE1A0_0001;
  localparam logic [15:0] HALF = 16'hBE05;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd_reg("R1 ctrl", 6'd0, 32'h0);
    rd_reg("R1 enable", 6'd1, 32'h0);
    rd_reg("R1 status", 6'd2, 32'h0);
    rd_reg("R1 cmp0", 6'd16, 32'h0);
    bus_rd("R1 pass", 32'h0000_0000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0);

    // comparator 0 as data fix at 0x1000
    wr(6'd0, 32'h0000_0009);               // mode bits 0 and 3
    wr(6'd8, 32'h1111_2222);
    wr(6'd11, 32'h3333_4444);
    wr(6'd16, 32'h0000_1000);
    wr(6'd3, WORD);
    wr(6'd4, {16'h0, HALF});
    bus_rd("R2 disabled", 32'h0000_1000, 32'hAAAA_0000, 32'hAAAA_0000, 1'b0);
    wr(6'd1, 32'h0000_0001);
    bus_rd("R4 fix", 32'h0000_1000, 32'hAAAA_0001, 32'h1111_2222, 1'b1);
    bus_rd("R3 bit0 ignored", 32'h0000_1001, 32'hAAAA_0002, 32'h1111_2222, 1'b1);
    bus_rd("R3 high ignored", 32'hFF80_1000, 32'hAAAA_0003, 32'h1111_2222, 1'b1);
    bus_rd("R3 miss", 32'h0000_1004, 32'hAAAA_0004, 32'hAAAA_0004, 1'b0);

    // R12 no event without valid
    @(posedge clk); #1;
    rd_addr_i = 32'h0000_1000; mem_rdata_i = 32'h5555_5555;
    #1 chk("R12 idle evt", {31'b0, patch_evt_o}, 32'h0);
    chk("R12 idle data", rd_data_o, 32'h5555_5555);

    // R7 select bit ignored on data fix
    wr(6'd16, 32'h0000_1001);
    bus_rd("R7 half ignored on fix", 32'h0000_1000, 32'hAAAA_0005, 32'h1111_2222, 1'b1);
    rd_reg("R10 src0", 6'd2, 32'h0);

    // R5 comparator 9 full word, opcode-only
    wr(6'd25, 32'h0000_2000);
    // R6 comparators 10/11 halfword lanes
    wr(6'd26, 32'h0000_3003);
    wr(6'd27, 32'h0000_3005);
    wr(6'd31, 32'h0000_5000);
    wr(6'd1, 32'h0000_8E01);
    bus_rd("R5 word", 32'h0000_2000, 32'hAAAA_0006, WORD, 1'b1);
    rd_reg("R10 src9", 6'd2, 32'd9);
    bus_rd("R6 upper lane", 32'h0000_3002, 32'h1234_5678, {HALF, 16'h5678}, 1'b1);
    bus_rd("R6 lower lane", 32'h0000_3004, 32'h1234_5678, {16'h1234, HALF}, 1'b1);
    rd_reg("R10 src11", 6'd2, 32'd11);
    bus_rd("R7 cmp15 word", 32'h0000_5000, 32'hAAAA_0007, WORD, 1'b1);
    rd_reg("R10 src15", 6'd2, 32'd15);

    // R9/R11 collision: cmp1 opcode, cmp3 data fix, same address
    wr(6'd17, 32'h0000_4000);
    wr(6'd19, 32'h0000_4000);
    wr(6'd1, 32'h0000_800B);
    bus_rd("R9 lowest wins", 32'h0000_4000, 32'hAAAA_0008, WORD, 1'b1);
    rd_reg("R11 coll set", 6'd2, 32'h0002_0001);
    bus_rd("R4 single", 32'h0000_1000, 32'hAAAA_0009, 32'h1111_2222, 1'b1);
    rd_reg("R11 sticky", 6'd2, 32'h0002_0000);
    wr(6'd2, 32'h0000_0000);
    rd_reg("R11 write0 no clear", 6'd2, 32'h0002_0000);
    wr(6'd2, 32'h0002_0000);
    rd_reg("R11 cleared", 6'd2, 32'h0000_0000);
    // R4 data fix through comparator 3 when comparator 1 disabled
    wr(6'd1, 32'h0000_0008);
    bus_rd("R4 fix3", 32'h0000_4000, 32'hAAAA_000A, 32'h3333_4444, 1'b1);
    rd_reg("R10 src3", 6'd2, 32'd3);

    // R8 global disable
    wr(6'd1, 32'h0000_800B);
    wr(6'd0, 32'h2000_0009);
    rd_reg("R8 ctrl rb", 6'd0, 32'h2000_0009);
    bus_rd("R8 pass", 32'h0000_4000, 32'hCAFE_F00D, 32'hCAFE_F00D, 1'b0);
    bus_rd("R8 pass2", 32'h0000_5000, 32'hCAFE_0001, 32'hCAFE_0001, 1'b0);
    rd_reg("R8 status held", 6'd2, 32'd3);
    wr(6'd0, 32'h0000_0009);
    bus_rd("R8 reenabled", 32'h0000_5000, 32'hCAFE_0002, WORD, 1'b1);

    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule